// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level page table in memory, using short 32-bit descriptors. A request carries the virtual address, the table base word and a translation-enable bit. It is accepted through a valid/ready handshake, and the block takes only one request at a time.

When translation is on, the walker reads the first-level descriptor. That descriptor is a 1 MB section, a pointer to a 1 KB second-level table of 256 entries, or a fault. For a table pointer, the walker reads the second-level entry. Its two low bits select a 64 KB large page, a 4 KB small page or a page fault. The result holds the physical address, three access-permission bits, the execute-never bit, the page size in bytes and a fault code. A one-cycle `done` pulse marks the result as valid. No result is cached. Permissions and domains are not checked.

The controller has three states:
- `ST_IDLE`: waits for a request.
  - Goes to `ST_L1` when a request is accepted with translation on.
  - Stays in `ST_IDLE` and completes directly when translation is off.
- `ST_L1`: holds the first-level read.
  - Goes to `ST_L2` on a response with a table pointer.
  - Goes back to `ST_IDLE` on a response with a section or a fault.
- `ST_L2`: holds the second-level read.
  - Goes back to `ST_IDLE` on its response.

Top module: `pt_walker`

## Requirements
- R1: After reset `req_ready`=1, `done`=0 and `mem_req_valid`=0. `req_ready` is high only in idle when no `done` pulse is showing, so it is low for the whole of a walk.
- R2: With `req_xlat_en`=0 the result is `res_paddr`=vaddr with ap, xn, size and fault all 0. `done` rises one cycle after acceptance, and the walk issues no memory read.
- R3: The first-level read address is {ttb[31:14], va[31:20], 2'b00}.
- R4: A first-level descriptor d with d[1:0]=2'b10 is a section:
  - paddr={d[31:20], va[19:0]}
  - ap={d[15], d[11:10]}
  - xn=d[4]
  - size=32'h0010_0000
  - fault=0
- R5: A first-level d[1:0] of 2'b00 or 2'b11 gives fault=5. On any fault, paddr, ap, xn and size are all 0.
- R6: A first-level d[1:0]=2'b01 is a table pointer. The second-level read address is {d[31:10], va[19:12], 2'b00}.
- R7: A second-level descriptor e with e[1:0]=2'b00 gives fault=7.
- R8: A second-level e[1:0]=2'b01 is a large page:
  - paddr={e[31:16], va[15:0]}
  - xn=e[15], even when e[0]=1
  - size=32'h0001_0000
- R9: A second-level e[1:0] of 2'b10 or 2'b11 is a small page:
  - paddr={e[31:12], va[11:0]}
  - xn=e[0], even when e[15]=1
  - size=32'h0000_1000
- R10: For a page, ap={e[9], e[5:4]}.
- R11: A large-page entry is not checked for replication. Only the one slot selected by va[19:12] is read, so an empty slot inside a 64 KB region gives fault=7.
- R12: `mem_req_addr` stays stable while `mem_req_valid` is high and no response has arrived. `done` is a one-cycle pulse in the cycle after the final response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ttb | input | 32 | Table base word; bits [31:14] are used |
| req_xlat_en | input | 1 | Translation enable |
| mem_req_valid | output | 1 | Word read request pending |
| mem_req_addr | output | 32 | Word read address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Read data word |
| done | output | 1 | One-cycle result strobe |
| res_paddr | output | 32 | Physical address |
| res_ap | output | 3 | Access-permission bits |
| res_xn | output | 1 | Execute-never |
| res_size | output | 32 | Mapped size in bytes |
| res_fault | output | 4 | 0 none, 5 first-level fault, 7 page fault |

## Verification
The bench targets the execute-never position.
- It uses a large page with bit 0 set and bit 15 clear, and a small page with bit 15 set and bit 0 clear.
- A walker that swapped the two positions would report the wrong xn on both.

It also targets the address slices.
- It maps a large page whose offset crosses the 4 KB boundary.
- A design that merged descriptor bits [15:12] into the large-page address would return the wrong physical address.
- It leaves one slot of a large region empty. A walker that decoded the region's first entry would translate that slot instead of faulting.

Last, it varies the memory latency. A walker that dropped its read address early, or that counted the response cycle twice, would return data from the wrong descriptor or a misplaced `done`.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int AW = 32;
    localparam int APW = 3;
    localparam int FW = 4;
    localparam logic [FW-1:0] FLT_NONE = 4'd0;
    localparam logic [FW-1:0] FLT_SECT = 4'd5;
    localparam logic [FW-1:0] FLT_PAGE = 4'd7;
    localparam logic [AW-1:0] SZ_SECT  = 32'h0010_0000;
    localparam logic [AW-1:0] SZ_LARGE = 32'h0001_0000;
    localparam logic [AW-1:0] SZ_SMALL = 32'h0000_1000;

    typedef enum logic [1:0] {
        L1K_FAULT,
        L1K_SECT,
        L1K_TABLE
    } l1_kind_e;

    typedef struct packed {
        logic [AW-1:0]  paddr;
        logic [APW-1:0] ap;
        logic           xn;
        logic [AW-1:0]  size;
        logic [FW-1:0]  fault;
    } ptw_res_t;
endpackage

// File: rtl/ptw_l1_dec.sv
module ptw_l1_dec
    import ptw_pkg::*;
(
    input  logic [AW-1:0] desc,
    input  logic [AW-1:0] va,
    output l1_kind_e      kind,
    output ptw_res_t      res,
    output logic [AW-1:0] l2_addr
);
    logic unused_bits;
    assign unused_bits = ^{desc[14:12], desc[9:5], desc[3:2], va[31:20]};

    assign l2_addr = {desc[31:10], va[19:12], 2'b00};

    always_comb begin
        res = '0;
        unique case (desc[1:0])
            2'b10: begin
                kind      = L1K_SECT;
                res.paddr = {desc[31:20], va[19:0]};
                res.ap    = {desc[15], desc[11:10]};
                res.xn    = desc[4];
                res.size  = SZ_SECT;
                res.fault = FLT_NONE;
            end
            2'b01: begin
                kind = L1K_TABLE;
            end
            default: begin
                kind      = L1K_FAULT;
                res.fault = FLT_SECT;
            end
        endcase
    end
endmodule

// File: rtl/ptw_l2_dec.sv
module ptw_l2_dec
    import ptw_pkg::*;
(
    input  logic [AW-1:0] desc,
    input  logic [AW-1:0] va,
    output ptw_res_t      res
);
    logic unused_bits;
    assign unused_bits = ^{desc[8:6], desc[3:2], va[31:16]};

    always_comb begin
        res = '0;
        unique case (desc[1:0])
            2'b00: begin
                res.fault = FLT_PAGE;
            end
            2'b01: begin
                res.paddr = {desc[31:16], va[15:0]};
                res.ap    = {desc[9], desc[5:4]};
                res.xn    = desc[15];
                res.size  = SZ_LARGE;
            end
            default: begin
                res.paddr = {desc[31:12], va[11:0]};
                res.ap    = {desc[9], desc[5:4]};
                res.xn    = desc[0];
                res.size  = SZ_SMALL;
            end
        endcase
    end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_vaddr,
    input  logic [AW-1:0] req_ttb,
    input  logic          req_xlat_en,
    output logic          mem_req_valid,
    output logic [AW-1:0] mem_req_addr,
    input  logic          mem_rsp_valid,
    input  l1_kind_e      l1_kind,
    input  ptw_res_t      l1_res,
    input  logic [AW-1:0] l1_l2_addr,
    input  ptw_res_t      l2_res,
    output logic [AW-1:0] va_q,
    output logic          done,
    output ptw_res_t      res
);
    typedef enum logic [1:0] {ST_IDLE, ST_L1, ST_L2} state_e;

    state_e        state_q, state_d;
    logic [AW-1:0] addr_q;
    ptw_res_t      res_q;
    logic          done_q;
    logic          accept;
    logic          unused_ttb;

    assign unused_ttb = ^req_ttb[13:0];
    assign accept     = req_valid && req_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept && req_xlat_en) state_d = ST_L1;
            ST_L1: begin
                if (mem_rsp_valid) begin
                    state_d = (l1_kind == L1K_TABLE) ? ST_L2 : ST_IDLE;
                end
            end
            ST_L2: if (mem_rsp_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            va_q   <= '0;
            res_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        va_q <= req_vaddr;
                        if (!req_xlat_en) begin
                            res_q       <= '0;
                            res_q.paddr <= req_vaddr;
                            done_q      <= 1'b1;
                        end else begin
                            addr_q <= {req_ttb[31:14], req_vaddr[31:20], 2'b00};
                        end
                    end
                end
                ST_L1: begin
                    if (mem_rsp_valid) begin
                        if (l1_kind == L1K_TABLE) begin
                            addr_q <= l1_l2_addr;
                        end else begin
                            res_q  <= l1_res;
                            done_q <= 1'b1;
                        end
                    end
                end
                ST_L2: begin
                    if (mem_rsp_valid) begin
                        res_q  <= l2_res;
                        done_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        req_ready     = (state_q == ST_IDLE) && !done_q;
        mem_req_valid = (state_q == ST_L1) || (state_q == ST_L2);
        mem_req_addr  = addr_q;
        done          = done_q;
        res           = res_q;
    end

    a_r12_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    a_r5_fault_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res.fault != FLT_NONE) |-> (res.paddr == '0 && res.ap == '0 && !res.xn && res.size == '0));
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [31:0]   req_vaddr,
    input  logic [31:0]   req_ttb,
    input  logic          req_xlat_en,
    output logic          mem_req_valid,
    output logic [31:0]   mem_req_addr,
    input  logic          mem_rsp_valid,
    input  logic [31:0]   mem_rsp_data,
    output logic          done,
    output logic [31:0]   res_paddr,
    output logic [2:0]    res_ap,
    output logic          res_xn,
    output logic [31:0]   res_size,
    output logic [3:0]    res_fault
);
    l1_kind_e      l1_kind;
    ptw_res_t      l1_res, l2_res, res;
    logic [AW-1:0] l2_addr, va_q;

    ptw_l1_dec i_l1 (
        .desc    (mem_rsp_data),
        .va      (va_q),
        .kind    (l1_kind),
        .res     (l1_res),
        .l2_addr (l2_addr)
    );

    ptw_l2_dec i_l2 (
        .desc (mem_rsp_data),
        .va   (va_q),
        .res  (l2_res)
    );

    ptw_ctrl i_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .req_ttb       (req_ttb),
        .req_xlat_en   (req_xlat_en),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .l1_kind       (l1_kind),
        .l1_res        (l1_res),
        .l1_l2_addr    (l2_addr),
        .l2_res        (l2_res),
        .va_q          (va_q),
        .done          (done),
        .res           (res)
    );

    assign res_paddr = res.paddr;
    assign res_ap    = res.ap;
    assign res_xn    = res.xn;
    assign res_size  = res.size;
    assign res_fault = res.fault;
endmodule

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;
    import ptw_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [31:0] req_vaddr = '0;
    logic [31:0] req_ttb = 32'h0000_4000;
    logic req_xlat_en = 1'b0;
    logic mem_req_valid;
    logic [31:0] mem_req_addr;
    logic mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic done;
    logic [31:0] res_paddr, res_size;
    logic [2:0] res_ap;
    logic res_xn;
    logic [3:0] res_fault;

    always #2.5 clk = ~clk;

    pt_walker i_pt_walker (.*);

    int errors = 0;
    int checks = 0;
    int reads = 0;
    int lat = 0;
    int wait_cnt = 0;
    logic [31:0] mem [int unsigned];

    typedef struct {
        ptw_res_t r;
        string    tag;
    } exp_t;
    exp_t sb_q[$];

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    function automatic ptw_res_t model(input logic [31:0] va, input logic en, output int nrd);
        ptw_res_t r;
        logic [31:0] d, e;
        r = '0;
        nrd = 0;
        if (!en) begin
            r.paddr = va;
            return r;
        end
        d = rd({req_ttb[31:14], va[31:20], 2'b00});
        nrd = 1;
        if (d[1:0] == 2'b10) begin
            r.paddr = {d[31:20], va[19:0]};
            r.ap = {d[15], d[11:10]};
            r.xn = d[4];
            r.size = 32'h0010_0000;
        end else if (d[1:0] == 2'b01) begin
            e = rd({d[31:10], va[19:12], 2'b00});
            nrd = 2;
            if (e[1:0] == 2'b00) r.fault = 4'd7;
            else if (e[1:0] == 2'b01) begin
                r.paddr = {e[31:16], va[15:0]};
                r.ap = {e[9], e[5:4]};
                r.xn = e[15];
                r.size = 32'h0001_0000;
            end else begin
                r.paddr = {e[31:12], va[11:0]};
                r.ap = {e[9], e[5:4]};
                r.xn = e[0];
                r.size = 32'h0000_1000;
            end
        end else begin
            r.fault = 4'd5;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory model with programmable latency
    always @(posedge clk) begin
        if (mem_req_valid && !mem_rsp_valid) begin
            if (wait_cnt >= lat) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= rd(mem_req_addr);
                reads         <= reads + 1;
                wait_cnt      <= 0;
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end else begin
            mem_rsp_valid <= 1'b0;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R12 unexpected done", 1, 0);
            end else begin
                exp_t x;
                ptw_res_t a;
                x = sb_q.pop_front();
                a = '{res_paddr, res_ap, res_xn, res_size, res_fault};
                check(a == x.r, x.tag, a, x.r);
            end
        end
        if (rst_n && mem_req_valid && req_ready)
            check(1'b0, "R1 ready during walk", 1, 0);
    end

    task automatic walk(input logic [31:0] va, input logic en, input string tag);
        exp_t x;
        int nrd, r0;
        x.r = model(va, en, nrd);
        x.tag = tag;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        r0 = reads;
        sb_q.push_back(x);
        req_vaddr = va;
        req_xlat_en = en;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (sb_q.size() != 0) @(negedge clk);
        check(reads - r0 == nrd, {tag, " read count"}, reads - r0, nrd);
    endtask

    initial begin
        #200000;
        check(1'b0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // first level: TTB 0x4000, entries at 0x4000 + idx*4
        mem[32'h0000_400C] = 32'h8000_8C12;  // idx 3: section, ap=111, xn=1
        mem[32'h0000_4010] = 32'h4560_0402;  // idx 4: section, ap=001, xn=0
        mem[32'h0000_4018] = 32'h1230_0003;  // idx 6: type 11 -> fault
        mem[32'h0000_401C] = 32'h0010_0001;  // idx 7: coarse at 0x0010_0000
        mem[32'h0010_02AC] = 32'h1234_D232;  // slot AB: small, bit15=1 bit0=0
        mem[32'h0010_02B0] = 32'hCAFE_F013;  // slot AC: small type 11, xn=1
        for (int s = 8'h10; s <= 8'h1F; s++)
            if (s != 8'h15) mem[32'h0010_0000 + s*4] = 32'hBEEF_8011;
        for (int s = 8'h20; s <= 8'h2F; s++)
            mem[32'h0010_0000 + s*4] = 32'h5555_0221;  // large, bit0=1, bit15=0

        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
        check(done == 1'b0, "R1 reset done", done, 0);
        check(mem_req_valid == 1'b0, "R1 reset mem_req_valid", mem_req_valid, 0);
        rst_n = 1'b1;

        lat = 0;
        walk(32'h1234_5678, 1'b0, "R2 disabled passthrough");
        walk(32'h0030_1234, 1'b1, "R3 R4 section ap xn");
        lat = 2;
        walk(32'h004F_FFFF, 1'b1, "R4 section second");
        walk(32'h0050_0000, 1'b1, "R5 type 00 fault");
        walk(32'h0060_0ABC, 1'b1, "R5 type 11 fault");
        lat = 1;
        walk(32'h007A_B123, 1'b1, "R6 R9 R10 small xn bit0");
        walk(32'h007A_C456, 1'b1, "R9 small type 11");
        lat = 3;
        walk(32'h0071_0ABC, 1'b1, "R8 large");
        walk(32'h0071_FABC, 1'b1, "R8 large offset above 4K");
        walk(32'h0071_5ABC, 1'b1, "R11 empty slot in large region");
        lat = 0;
        walk(32'h0072_3456, 1'b1, "R8 R10 large xn bit15");
        walk(32'h0079_9000, 1'b1, "R7 page fault");
        walk(32'hFFFF_FFFF, 1'b0, "R2 disabled all ones");

        // R12: done lasts one cycle and does not return
        repeat (3) @(negedge clk);
        check(done == 1'b0 && sb_q.size() == 0, "R12 no trailing done", done, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule